// File: doc/BRIEF.md
# Four-Phase Interpolating Pulse Shaper

This block shapes the transmit pulse for the in-phase and quadrature branches of a QAM modulator. Signed symbols enter at the symbol rate and shift into one tapped delay line per branch. For each symbol the filter produces four output samples. Each sample uses its own bank of tap weights, so one symbol step traces one full polyphase interpolation cycle. Every sample is the signed multiply-accumulate of the delay line against the bank selected by the current phase, plus an additive per-phase offset term. The result is then scaled down by a programmable arithmetic right shift. The shifted value is cut to the output width without clamping.

A single processing clock drives the block. A one-cycle symbol strobe marks each symbol boundary and restarts the phase count. Tap weights and offsets are written through a small write port into a staging copy. The staging copy is moved into the live banks at the next symbol boundary, so a sample never mixes old and new weights. The shift amount has its own write strobe. Both branches share the weights, the offsets and the shift amount.

Top module: `qamPulseShaper`

## Requirements
- R1: After reset, outValid, outPhase, iOut and qOut are all zero. Every tap weight and offset is zero, and the shift amount is 5. outValid stays low until the first symbol strobe.
- R2: Both delay lines move only on a clock edge where symStrobe is high. On that edge the new symbol enters tap 0, and tap k takes the old value of tap k-1.
- R3: One cycle after a strobe edge, the phase is 0. It then counts up by one each cycle, wrapping from 3 to 0, and returns to 0 at every strobe. Each sample is registered: the value computed in phase p appears on iOut and qOut one cycle later, with outValid high and outPhase equal to p. Once outValid goes high it stays high.
- R4: The sample for phase p is the signed value offset[p] + sum over k of weight[p][k] * tap[k]. Symbols and weights are two's complement.
- R5: coefAddr[6:5] selects the phase and coefAddr[4:0] selects the tap. Tap index 31 selects that phase's offset, which takes coefData[10:0] as an 11-bit signed value. The offset is added without being multiplied by any data.
- R6: The output is the full-width sum shifted arithmetically right by the shift amount (0 to 15), with the low bits truncated. Sum bit n drives output bit 0. A pulse on shiftWe loads shiftVal on that edge.
- R7: There is no saturation. iOut and qOut are the low 10 bits of the shifted sum, even when the value does not fit.
- R8: qOut is computed from the Q delay line with the same weights, offsets and shift amount as iOut.
- R9: A write with coefWe goes to a staging copy. The staging copy moves into the live banks on the next strobe edge. A write in the same cycle as a strobe becomes live only at the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, four cycles per symbol |
| rstN | input | 1 | Active-low synchronous reset |
| symStrobe | input | 1 | One-cycle symbol boundary marker |
| iSym | input | 4 | Signed in-phase symbol |
| qSym | input | 4 | Signed quadrature symbol |
| coefWe | input | 1 | Weight or offset write enable |
| coefAddr | input | 7 | Phase in bits 6:5, tap in bits 4:0 (31 = offset) |
| coefData | input | 12 | Signed write data |
| shiftWe | input | 1 | Shift amount write enable |
| shiftVal | input | 4 | New right-shift amount |
| outValid | output | 1 | Output sample valid |
| outPhase | output | 2 | Phase index of the current sample |
| iOut | output | 10 | Shaped in-phase sample |
| qOut | output | 10 | Shaped quadrature sample |

## Verification
A weight write and a symbol boundary can fall in the same clock cycle. Both the staging copy and the live banks are then updated on one edge. The bench provokes this by pulsing coefWe in the same cycle as symStrobe. It checks that the symbol which starts there still uses the old weight in all four phases, and that the new weight appears only from the next symbol on. A bench model predicts every sample from the written weights and the symbols sent in.

// File: rtl/qps_pkg.sv
package qps_pkg;
  parameter int PHASES  = 4;
  parameter int PH_W    = $clog2(PHASES);
  parameter int SHIFT_W = 4;

  // strobes and selectors from control to datapath
  typedef struct packed {
    logic               advance;   // symbol boundary: shift lines, load banks
    logic               sampleEn;  // compute and register an output sample
    logic [PH_W-1:0]    phase;     // live coefficient bank
    logic [SHIFT_W-1:0] shift;     // right-shift amount
  } qpsCtrl_t;
endpackage

// File: rtl/qpsControl.sv
module qpsControl
  import qps_pkg::*;
#(
  parameter int RESET_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               symStrobe,
  input  logic               shiftWe,
  input  logic [SHIFT_W-1:0] shiftVal,
  output qpsCtrl_t           ctrl
);
  logic               running;
  logic [PH_W-1:0]    phaseCnt;
  logic [SHIFT_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      phaseCnt <= '0;
      shiftReg <= SHIFT_W'(RESET_SHIFT);
    end else begin
      if (symStrobe) begin
        running  <= 1'b1;
        phaseCnt <= '0;
      end else if (running) begin
        phaseCnt <= phaseCnt + PH_W'(1);
      end
      if (shiftWe) shiftReg <= shiftVal;
    end
  end

  always_comb begin
    ctrl.advance  = symStrobe;
    ctrl.sampleEn = running;
    ctrl.phase    = phaseCnt;
    ctrl.shift    = shiftReg;
  end
endmodule

// File: rtl/qpsDatapath.sv
module qpsDatapath
  import qps_pkg::*;
#(
  parameter int TAPS   = 31,
  parameter int SYM_W  = 4,
  parameter int COEF_W = 12,
  parameter int OFF_W  = 11,
  parameter int OUT_W  = 10,
  parameter int BRANCH = 2,
  localparam int TAP_AW = $clog2(TAPS + 1),
  localparam int ADDR_W = PH_W + TAP_AW
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  qpsCtrl_t                         ctrl,
  input  logic [BRANCH-1:0][SYM_W-1:0]     symIn,
  input  logic                             coefWe,
  input  logic [ADDR_W-1:0]                coefAddr,
  input  logic [COEF_W-1:0]                coefData,
  output logic                             outValid,
  output logic [PH_W-1:0]                  outPhase,
  output logic [BRANCH-1:0][OUT_W-1:0]     outSample
);
  // accumulator wide enough to expose bit (max shift + OUT_W - 1)
  localparam int ACC_W = (2 ** SHIFT_W - 1) + OUT_W;
  localparam logic [TAP_AW-1:0] OFF_TAP = TAP_AW'(TAPS);

  logic signed [COEF_W-1:0] stageCoef [PHASES][TAPS];
  logic signed [COEF_W-1:0] liveCoef  [PHASES][TAPS];
  logic signed [OFF_W-1:0]  stageOff  [PHASES];
  logic signed [OFF_W-1:0]  liveOff   [PHASES];

  logic [PH_W-1:0]   wrPhase;
  logic [TAP_AW-1:0] wrTap;
  assign wrPhase = coefAddr[ADDR_W-1:TAP_AW];
  assign wrTap   = coefAddr[TAP_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PHASES; p++) begin
        stageOff[p] <= '0;
        liveOff[p]  <= '0;
        for (int k = 0; k < TAPS; k++) begin
          stageCoef[p][k] <= '0;
          liveCoef[p][k]  <= '0;
        end
      end
    end else begin
      if (ctrl.advance) begin
        liveCoef <= stageCoef;
        liveOff  <= stageOff;
      end
      if (coefWe) begin
        if (wrTap == OFF_TAP)
          stageOff[wrPhase] <= coefData[OFF_W-1:0];
        else if (wrTap < OFF_TAP)
          stageCoef[wrPhase][wrTap] <= coefData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPhase <= '0;
    end else if (ctrl.sampleEn) begin
      outValid <= 1'b1;
      outPhase <= ctrl.phase;
    end
  end

  for (genvar b = 0; b < BRANCH; b++) begin : g_branch
    logic signed [SYM_W-1:0] line [TAPS];
    logic signed [ACC_W-1:0] acc;
    logic [OUT_W-1:0]        scaled;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < TAPS; k++) line[k] <= '0;
      end else if (ctrl.advance) begin
        line[0] <= symIn[b];
        for (int k = 1; k < TAPS; k++) line[k] <= line[k-1];
      end
    end

    always_comb begin
      acc = ACC_W'(liveOff[ctrl.phase]);
      for (int k = 0; k < TAPS; k++)
        acc = acc + ACC_W'(liveCoef[ctrl.phase][k]) * ACC_W'(line[k]);
      scaled = OUT_W'(acc >>> ctrl.shift);
    end

    always_ff @(posedge clk) begin
      if (!rstN)              outSample[b] <= '0;
      else if (ctrl.sampleEn) outSample[b] <= scaled;
    end
  end
endmodule

// File: rtl/qamPulseShaper.sv
module qamPulseShaper
  import qps_pkg::*;
#(
  parameter int TAPS        = 31,
  parameter int SYM_W       = 4,
  parameter int COEF_W      = 12,
  parameter int OFF_W       = 11,
  parameter int OUT_W       = 10,
  parameter int RESET_SHIFT = 5,
  localparam int ADDR_W = PH_W + $clog2(TAPS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               symStrobe,
  input  logic [SYM_W-1:0]   iSym,
  input  logic [SYM_W-1:0]   qSym,
  input  logic               coefWe,
  input  logic [ADDR_W-1:0]  coefAddr,
  input  logic [COEF_W-1:0]  coefData,
  input  logic               shiftWe,
  input  logic [SHIFT_W-1:0] shiftVal,
  output logic               outValid,
  output logic [PH_W-1:0]    outPhase,
  output logic [OUT_W-1:0]   iOut,
  output logic [OUT_W-1:0]   qOut
);
  qpsCtrl_t                ctrl;
  logic [1:0][OUT_W-1:0]   samples;

  qpsControl #(.RESET_SHIFT(RESET_SHIFT)) u_control (
    .clk(clk), .rstN(rstN), .symStrobe(symStrobe),
    .shiftWe(shiftWe), .shiftVal(shiftVal), .ctrl(ctrl)
  );

  qpsDatapath #(
    .TAPS(TAPS), .SYM_W(SYM_W), .COEF_W(COEF_W), .OFF_W(OFF_W),
    .OUT_W(OUT_W), .BRANCH(2)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .symIn({qSym, iSym}),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outPhase(outPhase), .outSample(samples)
  );

  assign iOut = samples[0];
  assign qOut = samples[1];
endmodule

// File: rtl/qpsChecker.sv
module qpsChecker #(
  parameter int OUT_W = 10,
  parameter int PH_W  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             symStrobe,
  input logic             outValid,
  input logic [PH_W-1:0]  outPhase,
  input logic [OUT_W-1:0] iOut,
  input logic [OUT_W-1:0] qOut
);
  // R1: outputs stay at their reset value while no sample is valid
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (iOut == '0 && qOut == '0 && outPhase == '0));

  // R1: no valid sample appears without a strobe
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !symStrobe && !$past(symStrobe)) |=> !outValid);

  // R3: first sample after a strobe carries phase 0
  a_r3_phase_start: assert property (@(posedge clk) disable iff (!rstN)
    symStrobe |-> ##2 (outValid && outPhase == '0));

  // R3: phase steps by one when no strobe intervened
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(symStrobe)) |=> (outPhase == $past(outPhase) + PH_W'(1)));

  // R3: valid stays high once running
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> outValid);
endmodule

bind qamPulseShaper qpsChecker #(.OUT_W(OUT_W), .PH_W(qps_pkg::PH_W)) u_qpsChecker (
  .clk(clk), .rstN(rstN), .symStrobe(symStrobe), .outValid(outValid),
  .outPhase(outPhase), .iOut(iOut), .qOut(qOut)
);

// File: tb/test_qamPulseShaper.sv
`timescale 1ns/1ps
module test_qamPulseShaper;
  localparam real CLK_NS = 8.0;
  localparam int  NT = 31;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symStrobe = 1'b0;
  logic [3:0] iSym = '0, qSym = '0;
  logic       coefWe = 1'b0;
  logic [6:0] coefAddr = '0;
  logic [11:0] coefData = '0;
  logic       shiftWe = 1'b0;
  logic [3:0] shiftVal = '0;
  logic       outValid;
  logic [1:0] outPhase;
  logic [9:0] iOut, qOut;

  int checks = 0, failures = 0;

  // bench model state
  int shCoef [4][NT];
  int acCoef [4][NT];
  int shOff [4], acOff [4];
  int iD [NT], qD [NT];
  int shiftM = 5;

  always #(CLK_NS/2) clk = ~clk;

  qamPulseShaper i_qamPulseShaper (
    .clk(clk), .rstN(rstN), .symStrobe(symStrobe), .iSym(iSym), .qSym(qSym),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .shiftWe(shiftWe), .shiftVal(shiftVal), .outValid(outValid),
    .outPhase(outPhase), .iOut(iOut), .qOut(qOut)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expOut(int p, bit useQ);
    longint acc = longint'(acOff[p]);
    for (int k = 0; k < NT; k++)
      acc += longint'(acCoef[p][k]) * longint'(useQ ? qD[k] : iD[k]);
    acc = acc >>> shiftM;
    return int'(acc[9:0]);
  endfunction

  task automatic doWrite(int ph, int tap, int val);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = {2'(ph), 5'(tap)}; coefData = 12'(val);
    if (tap == NT) shOff[ph] = val; else shCoef[ph][tap] = val;
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic setShift(int v);
    @(negedge clk);
    shiftWe = 1'b1; shiftVal = 4'(v); shiftM = v;
    @(negedge clk);
    shiftWe = 1'b0;
  endtask

  // one symbol; optional write in the strobe cycle; checks all four phases
  task automatic pushSym(int iv, int qv, string req, bit wr = 0,
                         int wp = 0, int wt = 0, int wv = 0);
    @(negedge clk);
    symStrobe = 1'b1; iSym = 4'(iv); qSym = 4'(qv);
    acCoef = shCoef; acOff = shOff;
    for (int k = NT-1; k > 0; k--) begin iD[k] = iD[k-1]; qD[k] = qD[k-1]; end
    iD[0] = iv; qD[0] = qv;
    if (wr) begin
      coefWe = 1'b1; coefAddr = {2'(wp), 5'(wt)}; coefData = 12'(wv);
      if (wt == NT) shOff[wp] = wv; else shCoef[wp][wt] = wv;
    end
    @(negedge clk);
    symStrobe = 1'b0; coefWe = 1'b0;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      chk("R3 valid", int'(outValid), 1);
      chk("R3 phase", int'(outPhase), p);
      chk(req, int'(iOut), expOut(p, 1'b0));
      chk("R8 q branch", int'(qOut), expOut(p, 1'b1));
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(outValid), 0);
    chk("R1 iOut", int'(iOut), 0);
    chk("R1 qOut", int'(qOut), 0);
    chk("R1 phase", int'(outPhase), 0);
    pushSym(5, -3, "R1 zero weights");
  endtask

  task automatic testImpulse();
    doWrite(0, 0, 100);
    doWrite(1, 1, -50);
    doWrite(2, 0, 7);
    doWrite(3, 2, 300);
    doWrite(3, 30, -2000);
    pushSym(3, -2, "R4 mac");
    pushSym(-8, 7, "R2 line");
    pushSym(7, -8, "R4 mac");
    for (int n = 0; n < 28; n++) pushSym(n % 8 - 4, 3 - n % 8, "R2 deep tap");
  endtask

  task automatic testOffset();
    doWrite(1, 31, -1024);
    doWrite(3, 31, 1023);
    doWrite(0, 31, 37);
    pushSym(1, 1, "R5 offset");
    pushSym(0, 0, "R5 offset");
  endtask

  task automatic testShift();
    setShift(0);  pushSym(-5, 6, "R6 shift 0");
    setShift(15); pushSym(2, -1, "R6 shift 15");
    setShift(9);  pushSym(-7, 4, "R6 shift 9");
    setShift(3);  pushSym(6, -6, "R6 shift 3");
  endtask

  task automatic testWrap();
    for (int k = 0; k < NT; k++) doWrite(2, k, 2047);
    setShift(0);
    for (int n = 0; n < 6; n++) pushSym(-8, 7, "R7 no clamp");
    setShift(4);
    pushSym(-8, -8, "R7 no clamp");
  endtask

  task automatic testStaged();
    setShift(2);
    pushSym(1, 2, "R9 write with strobe", 1'b1, 0, 0, -2048);
    pushSym(3, -4, "R9 after boundary");
    doWrite(1, 31, 500);
    pushSym(-1, 5, "R9 staged write");
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      shOff[p] = 0; acOff[p] = 0;
      for (int k = 0; k < NT; k++) begin shCoef[p][k] = 0; acCoef[p][k] = 0; end
    end
    for (int k = 0; k < NT; k++) begin iD[k] = 0; qD[k] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testImpulse();
    testOffset();
    testShift();
    testWrap();
    testStaged();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule